// File: doc/BRIEF.md
# UART Baud Tick Generator

This block derives the two timing strobes a UART needs from its functional clock. A first counter divides the clock by `BRD + 2` and marks every wrap with a one-clock sample strobe. A second counter counts those strobes and marks every M-th one with a one-clock bit strobe. M is 16, X + 1 or 1, chosen by two control bits of a 32-bit settings register. The bit rate is therefore `clk / (M * (BRD + 2))`.

Software writes the register through a plain write strobe and can read the stored value back. Bits outside the defined fields are dropped. Each mode has a legality rule. A registered valid flag reports whether the stored settings obey the rule of the active mode. While they do not, both strobes stay low. Every register write restarts both counters from zero, so the new ratio never starts from a partial count left over from the old settings. An IrDA-mode input forces the fixed divide-by-16 prescale whatever the register holds.

Top module: `baudgen_top`

## Requirements
- R1: After reset, `cfg_rdata` is 0 and `cfg_valid` is 1. The block then runs with BRD = 0 and M = 16: the first sample strobe is seen 2 clocks after the last reset edge and the first bit strobe 32 clocks after it.
- R2: A write stores `cfg_wdata & 32'h3F00_FFFF`, and `cfg_rdata` shows it from the next clock. The fields are: BRD in [15:0], X in [27:24], unity-select in bit 28, prescale-enable in bit 29.
- R3: In every legal mode, the sample strobe repeats every BRD + 2 clocks. The first strobe after a write comes BRD + 2 clocks after the write edge.
- R4: With prescale-enable = 0, M is 16, and unity-select and X have no effect on either strobe.
- R5: With prescale-enable = 1 and unity-select = 0, M = X + 1. X = 8 is the smallest legal value.
- R6: With prescale-enable = 1 and unity-select = 1, M = 1: every sample strobe is also a bit strobe. BRD = 3 is the smallest legal value.
- R7: In the X + 1 mode with X < 8, `cfg_valid` is 0 and neither strobe fires.
- R8: In the unity mode with BRD < 3, `cfg_valid` is 0 and neither strobe fires.
- R9: While `irda_mode` is 1, M is 16 and the settings count as legal, whatever bits 28 and 29 hold.
- R10: A write clears both counters. The next sample strobe comes exactly BRD + 2 clocks after the write edge, even when the write lands mid-count.
- R11: Each strobe is high for one clock at a time. The bit strobe is high only in a clock where the sample strobe is also high.
- R12: `cfg_valid` shows the legality of the stored settings with one clock of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART functional clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Settings register write strobe |
| cfg_wdata | input | 32 | Settings register write data |
| irda_mode | input | 1 | Forces the divide-by-16 prescale |
| cfg_rdata | output | 32 | Stored settings, undefined bits zero |
| cfg_valid | output | 1 | Stored settings are legal for the active mode |
| sample_tick | output | 1 | Oversampling strobe, one clock wide |
| baud_tick | output | 1 | Bit-rate strobe, one clock wide |

## Verification
The hardest case to reach from the ports is a rewrite that lands while the first counter is part-way through a long period. To create it, the bench programs a divisor of 9, waits five clocks so the count is mid-way, and writes the same value again. It then checks that the first sample strobe arrives a full eleven clocks after the second write, not six. The legality boundaries come next, with X of 7 and 8 and unity-mode BRD of 2 and 3. Finally, IrDA mode is used to turn an otherwise illegal unity setting into a working divide-by-16 one, and releasing it makes the same setting illegal again.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;
  localparam int REG_W   = 32;
  localparam int BRD_W   = 16;
  localparam int BRD_LSB = 0;
  localparam int X_W     = 4;
  localparam int X_LSB   = 24;
  localparam int ONE_BIT = 28;
  localparam int EN_BIT  = 29;

  localparam logic [REG_W-1:0] CFG_MASK =
      ((((REG_W)'(1) << BRD_W) - 1) << BRD_LSB) |
      ((((REG_W)'(1) << X_W) - 1) << X_LSB) |
      ((REG_W)'(1) << ONE_BIT) |
      ((REG_W)'(1) << EN_BIT);

  typedef enum logic [1:0] {
    PRE_FIXED,
    PRE_XPLUS1,
    PRE_UNITY
  } pre_mode_e;
endpackage

// File: rtl/baudgen_cfg.sv
module baudgen_cfg
  import baudgen_pkg::*;
#(
  parameter int FIXED_M = 16,
  parameter int X_MIN   = 8,
  parameter int BRD_MIN = 3,
  parameter int PRE_CW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_W-1:0]  wdata,
  input  logic              irda_mode,
  output logic [REG_W-1:0]  cfg_q,
  output logic [BRD_W-1:0]  brd,
  output logic [PRE_CW-1:0] pre_last,
  output logic              legal,
  output logic              valid_q
);
  logic [X_W-1:0] x_fld;
  logic           one_sel;
  logic           pre_en;
  pre_mode_e      mode;

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (we) cfg_q <= wdata & CFG_MASK;
  end

  assign brd     = cfg_q[BRD_LSB +: BRD_W];
  assign x_fld   = cfg_q[X_LSB +: X_W];
  assign one_sel = cfg_q[ONE_BIT];
  assign pre_en  = cfg_q[EN_BIT];

  always_comb begin
    if (irda_mode || !pre_en) mode = PRE_FIXED;
    else if (one_sel)         mode = PRE_UNITY;
    else                      mode = PRE_XPLUS1;
  end

  always_comb begin
    pre_last = '0;
    legal    = 1'b1;
    case (mode)
      PRE_FIXED:  pre_last = PRE_CW'(FIXED_M - 1);
      PRE_XPLUS1: begin
        pre_last = PRE_CW'(x_fld);
        legal    = (int'(x_fld) >= X_MIN);
      end
      PRE_UNITY:  legal = (int'(brd) >= BRD_MIN);
      default:    legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b1;
    else     valid_q <= legal;
  end
endmodule

// File: rtl/baudgen_div.sv
module baudgen_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] brd,
  output logic         wrap,
  output logic         tick
);
  localparam int CW = W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  assign last = {1'b0, brd} + CW'(1);
  assign wrap = en && !clr && (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (wrap) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baudgen_pre.sv
module baudgen_pre #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          step,
  input  logic [CW-1:0] last,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (step) begin
      if (cnt >= last) begin
        cnt  <= '0;
        tick <= 1'b1;
      end else begin
        cnt  <= cnt + CW'(1);
        tick <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/baudgen_top.sv
module baudgen_top
  import baudgen_pkg::*;
#(
  parameter int FIXED_M = 16,
  parameter int X_MIN   = 8,
  parameter int BRD_MIN = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  input  logic             irda_mode,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             cfg_valid,
  output logic             sample_tick,
  output logic             baud_tick
);
  localparam int FM_W   = $clog2(FIXED_M);
  localparam int PRE_CW = (X_W > FM_W) ? X_W : FM_W;

  logic [BRD_W-1:0]  brd;
  logic [PRE_CW-1:0] pre_last;
  logic              legal;
  logic              s_wrap;

  baudgen_cfg #(
    .FIXED_M(FIXED_M), .X_MIN(X_MIN), .BRD_MIN(BRD_MIN), .PRE_CW(PRE_CW)
  ) i_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .irda_mode(irda_mode), .cfg_q(cfg_rdata), .brd(brd),
    .pre_last(pre_last), .legal(legal), .valid_q(cfg_valid)
  );

  baudgen_div #(.W(BRD_W)) i_div (
    .clk(clk), .rst(rst), .clr(cfg_we), .en(legal), .brd(brd),
    .wrap(s_wrap), .tick(sample_tick)
  );

  baudgen_pre #(.CW(PRE_CW)) i_pre (
    .clk(clk), .rst(rst), .clr(cfg_we), .en(legal), .step(s_wrap),
    .last(pre_last), .tick(baud_tick)
  );
endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk
  import baudgen_pkg::*;
#(
  parameter int X_MIN   = 8,
  parameter int BRD_MIN = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [REG_W-1:0] cfg_wdata,
  input logic             irda_mode,
  input logic [REG_W-1:0] cfg_rdata,
  input logic             cfg_valid,
  input logic             sample_tick,
  input logic             baud_tick
);
  logic lgl;
  always_comb begin
    if (irda_mode || !cfg_rdata[EN_BIT]) lgl = 1'b1;
    else if (cfg_rdata[ONE_BIT])
      lgl = int'(cfg_rdata[BRD_LSB +: BRD_W]) >= BRD_MIN;
    else
      lgl = int'(cfg_rdata[X_LSB +: X_W]) >= X_MIN;
  end

  a_r2_masked_store: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & CFG_MASK));

  a_r10_write_clears: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!sample_tick && !baud_tick));

  a_r7_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    !lgl |=> (!sample_tick && !baud_tick));

  a_r11_sample_one_wide: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick);

  a_r11_baud_with_sample: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> sample_tick);

  a_r12_valid_lag: assert property (@(posedge clk) disable iff (rst)
    !cfg_we |=> (cfg_valid == $past(lgl)));
endmodule

bind baudgen_top baudgen_chk #(.X_MIN(X_MIN), .BRD_MIN(BRD_MIN)) i_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .irda_mode(irda_mode), .cfg_rdata(cfg_rdata), .cfg_valid(cfg_valid),
  .sample_tick(sample_tick), .baud_tick(baud_tick)
);

// File: tb/test_baudgen_top.sv
`timescale 1ns/1ps
module test_baudgen_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        irda_mode = 1'b0;
  logic [31:0] cfg_rdata;
  logic        cfg_valid;
  logic        sample_tick;
  logic        baud_tick;

  int n_run = 0;
  int n_fail = 0;
  int fs, ns, fb, nb, bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  baudgen_top i_baudgen_top (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .irda_mode(irda_mode), .cfg_rdata(cfg_rdata), .cfg_valid(cfg_valid),
    .sample_tick(sample_tick), .baud_tick(baud_tick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // k = 0 is the negedge right after the write/reset edge
  task automatic measure(input int n);
    bit prev_s = 1'b0;
    fs = 0; ns = 0; fb = 0; nb = 0; bad = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (sample_tick) begin
        if (fs == 0) fs = k;
        ns++;
        if (prev_s) bad++;
      end
      if (baud_tick) begin
        if (fb == 0) fb = k;
        nb++;
        if (!sample_tick) bad++;
      end
      prev_s = sample_tick;
    end
  endtask

  task automatic expect_rate(input string req, input int p, input int m, input int n);
    measure(n);
    chk(fs == p, req, fs, p);
    chk(ns == n / p, req, ns, n / p);
    chk(fb == p * m, req, fb, p * m);
    chk(nb == n / (p * m), req, nb, n / (p * m));
    chk(bad == 0, "R11", bad, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(cfg_rdata == 32'h0, "R1 rdata", int'(cfg_rdata), 0);
    chk(cfg_valid == 1'b1, "R1 valid", int'(cfg_valid), 1);
    expect_rate("R1", 2, 16, 70);
  endtask

  task automatic t_mask;
    wr(32'hFFFF_FFFF);
    chk(cfg_rdata == 32'h3F00_FFFF, "R2 mask", int'(cfg_rdata), 32'h3F00_FFFF);
    wr(32'hC0F0_1234);
    chk(cfg_rdata == 32'h0000_1234, "R2 mask", int'(cfg_rdata), 32'h0000_1234);
  endtask

  task automatic t_fixed_ignores;
    wr(32'h1300_0001);
    expect_rate("R4 R3", 3, 16, 100);
    chk(cfg_valid == 1'b1, "R4 valid", int'(cfg_valid), 1);
  endtask

  task automatic t_xplus1;
    wr(32'h2800_0000);
    expect_rate("R5 X=8", 2, 9, 40);
    chk(cfg_valid == 1'b1, "R5 valid", int'(cfg_valid), 1);
    wr(32'h2A00_0005);
    expect_rate("R5 X=10", 7, 11, 160);
  endtask

  task automatic t_unity;
    wr(32'h3000_0003);
    expect_rate("R6", 5, 1, 30);
    chk(cfg_valid == 1'b1, "R6 valid", int'(cfg_valid), 1);
  endtask

  task automatic t_illegal_x;
    wr(32'h2700_0004);
    measure(50);
    chk(ns == 0 && nb == 0, "R7 ticks", ns + nb, 0);
    chk(cfg_valid == 1'b0, "R7 valid", int'(cfg_valid), 0);
  endtask

  task automatic t_illegal_brd;
    wr(32'h3000_0002);
    measure(50);
    chk(ns == 0 && nb == 0, "R8 ticks", ns + nb, 0);
    chk(cfg_valid == 1'b0, "R8 valid", int'(cfg_valid), 0);
  endtask

  task automatic t_irda;
    @(negedge clk);
    irda_mode = 1'b1;
    wr(32'h3000_0000);
    expect_rate("R9", 2, 16, 70);
    chk(cfg_valid == 1'b1, "R9 valid", int'(cfg_valid), 1);
    irda_mode = 1'b0;
    measure(40);
    chk(ns == 0 && nb == 0, "R8 after irda", ns + nb, 0);
    chk(cfg_valid == 1'b0, "R8 after irda valid", int'(cfg_valid), 0);
  endtask

  task automatic t_restart;
    wr(32'h0000_0009);
    measure(5);
    chk(ns == 0, "R10 before", ns, 0);
    wr(32'h0000_0009);
    measure(30);
    chk(fs == 11, "R10 first", fs, 11);
    chk(ns == 2, "R10 count", ns, 2);
  endtask

  task automatic t_valid_lag;
    wr(32'h0000_0000);
    @(negedge clk);
    chk(cfg_valid == 1'b1, "R12 legal", int'(cfg_valid), 1);
    wr(32'h2000_0000);
    chk(cfg_valid == 1'b1, "R12 lag", int'(cfg_valid), 1);
    @(negedge clk);
    chk(cfg_valid == 1'b0, "R12 follow", int'(cfg_valid), 0);
  endtask

  initial begin
    t_reset;
    t_mask;
    t_fixed_ignores;
    t_xplus1;
    t_unity;
    t_illegal_x;
    t_illegal_brd;
    t_irda;
    t_restart;
    t_valid_lag;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule